// File: doc/BRIEF.md
# Two-Phase Row Write Sequencer

This block programs one complete row of a non-volatile array. Each cell of the array stores its bit as a complementary pair of resistive elements placed between a top and a bottom source line. A write request gives a row index, a data word and a phase length, and is taken on a one-cycle start strobe. The sequencer then runs two fixed-polarity phases.

In the first phase both source lines of the chosen row are raised. A column whose bit is 0 has its write bitline held low, so that cell sees a voltage across it and becomes 0. A column whose bit is 1 has its bitline driven high, so both terminals sit at the same potential and that cell keeps its value. The second phase reverses this. Both source lines are low, and only the columns whose bit is 1 see a voltage, so they become 1. Every column of the row is handled in the same two phases.

The block drives digital enables only. Voltage levels belong to the analog drivers that follow it. An idle gap of all-low enables separates the two phases, so the drivers of the two polarities never overlap. Done pulses once the row is complete.

Top module: `wr_row_seq`

## Requirements
- R1: After reset, every wordline, source-line and bitline enable is low, and busy_o and done_o are low.
- R2: Phase one begins in the cycle after the clock edge that samples start_i. For L cycles it raises wwl_o, slt_o and slb_o of the chosen row only, and it drives wbl_o equal to the data word (bit c = 1 drives column c high).
- R3: Between the two phases there are exactly GAP_CYC cycles in which every wordline, source-line and bitline enable is low. Any cycle with no wordline active also has every bitline low.
- R4: Phase two lasts L cycles. It raises wwl_o of the chosen row, keeps all source lines low, and drives wbl_o equal to the data word.
- R5: For the whole operation, the wordline and both source lines of every row that was not chosen stay low. At most one wordline is ever high.
- R6: done_o is high for exactly one cycle, in the cycle after the last phase-two cycle. busy_o is high from the first phase-one cycle through the done cycle, which is 2L+GAP_CYC+1 cycles in total.
- R7: A start strobe that arrives while busy_o is high is ignored. It does not change the row, the data or the timing of the operation in progress.
- R8: L is the value of len_i sampled with start_i. A value of 0 is treated as 1.
- R9: When done_o is seen, a cell model driven by the enables holds the data word in the chosen row, with the 0 columns written in phase one and the 1 columns written in phase two. Cells of every other row are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request strobe |
| row_i | input | ROW_W | Row to write |
| data_i | input | COLS | Word to store |
| len_i | input | CNT_W | Cycles per phase (0 means 1) |
| wwl_o | output | ROWS | Write wordline enables |
| slt_o | output | ROWS | Top source-line high enables |
| slb_o | output | ROWS | Bottom source-line high enables |
| wbl_o | output | COLS | Write bitline high enables |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Row complete pulse |

## Verification
With start_i sampled at edge 0, the enables seen at the following falling edges follow a fixed schedule. Offsets 0 to L-1 are phase one, the next GAP_CYC offsets are the gap, the next L are phase two, and offset 2L+GAP_CYC is the done cycle. The monitor keeps a count of falling edges since busy_o rose. At each of those edges it compares all enables against the schedule of the transaction at the head of the scoreboard queue. At done it compares the bench's cell array against the expected contents of every row. Each check is therefore tied to the exact cycle in which the registered state has taken the value under test.

// File: rtl/wr_seq_pkg.sv
package wr_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_PH0  = 3'd1,
        ST_GAP  = 3'd2,
        ST_PH1  = 3'd3,
        ST_DONE = 3'd4
    } seq_state_e;

endpackage

// File: rtl/wr_phase_timer.sv
module wr_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expired_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (load_i) begin
            tmr_d.cnt = load_val_i;
        end else if (tmr_q.cnt != '0) begin
            tmr_d.cnt = tmr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign expired_o = (tmr_q.cnt == '0);

endmodule

// File: rtl/wr_row_drv.sv
module wr_row_drv #(
    parameter int ROWS  = 8,
    parameter int ROW_W = 3
) (
    input  logic [ROW_W-1:0] row_i,
    input  logic             wl_en_i,
    input  logic             sl_en_i,
    output logic [ROWS-1:0]  wwl_o,
    output logic [ROWS-1:0]  slt_o,
    output logic [ROWS-1:0]  slb_o
);

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic hit;
        assign hit      = (row_i == ROW_W'(r));
        assign wwl_o[r] = wl_en_i & hit;
        assign slt_o[r] = sl_en_i & hit;
        assign slb_o[r] = sl_en_i & hit;
    end

endmodule

// File: rtl/wr_col_drv.sv
module wr_col_drv #(
    parameter int COLS = 16
) (
    input  logic            en_i,
    input  logic [COLS-1:0] data_i,
    output logic [COLS-1:0] wbl_o
);

    for (genvar c = 0; c < COLS; c++) begin : g_col
        assign wbl_o[c] = en_i & data_i[c];
    end

endmodule

// File: rtl/wr_row_seq.sv
module wr_row_seq
    import wr_seq_pkg::*;
#(
    parameter int ROWS    = 8,
    parameter int COLS    = 16,
    parameter int CNT_W   = 8,
    parameter int GAP_CYC = 1,
    localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [ROW_W-1:0] row_i,
    input  logic [COLS-1:0]  data_i,
    input  logic [CNT_W-1:0] len_i,
    output logic [ROWS-1:0]  wwl_o,
    output logic [ROWS-1:0]  slt_o,
    output logic [ROWS-1:0]  slb_o,
    output logic [COLS-1:0]  wbl_o,
    output logic             busy_o,
    output logic             done_o
);

    localparam logic [CNT_W-1:0] GAP_LOAD = CNT_W'((GAP_CYC > 0 ? GAP_CYC : 1) - 1);

    typedef struct packed {
        seq_state_e       st;
        logic [ROW_W-1:0] row;
        logic [COLS-1:0]  data;
        logic [CNT_W-1:0] len_m1;
    } seq_t;

    seq_t             s_d, s_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_exp;
    logic             wl_en, sl_en, bl_en;

    always_comb begin
        s_d      = s_q;
        tmr_load = 1'b0;
        tmr_val  = s_q.len_m1;
        unique case (s_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    s_d.row    = row_i;
                    s_d.data   = data_i;
                    s_d.len_m1 = (len_i == '0) ? '0 : len_i - 1'b1;
                    s_d.st     = ST_PH0;
                    tmr_load   = 1'b1;
                    tmr_val    = (len_i == '0) ? '0 : len_i - 1'b1;
                end
            end
            ST_PH0: begin
                if (tmr_exp) begin
                    s_d.st   = ST_GAP;
                    tmr_load = 1'b1;
                    tmr_val  = GAP_LOAD;
                end
            end
            ST_GAP: begin
                if (tmr_exp) begin
                    s_d.st   = ST_PH1;
                    tmr_load = 1'b1;
                    tmr_val  = s_q.len_m1;
                end
            end
            ST_PH1: begin
                if (tmr_exp) begin
                    s_d.st = ST_DONE;
                end
            end
            ST_DONE: begin
                s_d.st = ST_IDLE;
            end
            default: begin
                s_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, row: '0, data: '0, len_m1: '0};
        end else begin
            s_q <= s_d;
        end
    end

    wr_phase_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expired_o  (tmr_exp)
    );

    assign wl_en = (s_q.st == ST_PH0) || (s_q.st == ST_PH1);
    assign sl_en = (s_q.st == ST_PH0);
    assign bl_en = wl_en;

    wr_row_drv #(.ROWS(ROWS), .ROW_W(ROW_W)) u_row (
        .row_i   (s_q.row),
        .wl_en_i (wl_en),
        .sl_en_i (sl_en),
        .wwl_o   (wwl_o),
        .slt_o   (slt_o),
        .slb_o   (slb_o)
    );

    wr_col_drv #(.COLS(COLS)) u_col (
        .en_i   (bl_en),
        .data_i (s_q.data),
        .wbl_o  (wbl_o)
    );

    assign busy_o = (s_q.st != ST_IDLE);
    assign done_o = (s_q.st == ST_DONE);

endmodule

// File: rtl/wr_row_seq_chk.sv
module wr_row_seq_chk #(
    parameter int ROWS = 8,
    parameter int COLS = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic [ROWS-1:0] wwl_o,
    input logic [ROWS-1:0] slt_o,
    input logic [ROWS-1:0] slb_o,
    input logic [COLS-1:0] wbl_o,
    input logic            busy_o,
    input logic            done_o
);

    // R5
    wwl_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wwl_o));

    // R2
    sl_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slt_o == slb_o);

    // R5
    sl_in_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slt_o & ~wwl_o) == '0);

    // R3
    bl_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wwl_o == '0) |-> (wbl_o == '0));

    // R3
    phase_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|slt_o) |=> ((|slt_o) || (wwl_o == '0)));

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6
    done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);

    // R7
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);

endmodule

bind wr_row_seq wr_row_seq_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wwl_o  (wwl_o),
    .slt_o  (slt_o),
    .slb_o  (slb_o),
    .wbl_o  (wbl_o),
    .busy_o (busy_o),
    .done_o (done_o)
);

// File: tb/tb_wr_row_seq.sv
module tb_wr_row_seq;

    localparam int ROWS  = 8;
    localparam int COLS  = 16;
    localparam int CNT_W = 8;
    localparam int GAP   = 1;
    localparam int ROW_W = 3;

    typedef struct {
        logic [ROW_W-1:0] row;
        logic [COLS-1:0]  data;
        int               len;
    } txn_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [ROW_W-1:0] row_i = '0;
    logic [COLS-1:0]  data_i = '0;
    logic [CNT_W-1:0] len_i = '0;
    logic [ROWS-1:0]  wwl_o, slt_o, slb_o;
    logic [COLS-1:0]  wbl_o;
    logic             busy_o, done_o;

    int checks = 0;
    int errors = 0;
    txn_t exp_q[$];
    logic [COLS-1:0] cells [ROWS];
    logic [COLS-1:0] shadow[ROWS];
    int txn_done = 0;

    always #2 clk = ~clk;

    wr_row_seq #(.ROWS(ROWS), .COLS(COLS), .CNT_W(CNT_W), .GAP_CYC(GAP)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .row_i(row_i),
        .data_i(data_i), .len_i(len_i), .wwl_o(wwl_o), .slt_o(slt_o),
        .slb_o(slb_o), .wbl_o(wbl_o), .busy_o(busy_o), .done_o(done_o)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // behavioural cell model: equal potential leaves a cell untouched
    always @(negedge clk) begin
        for (int r = 0; r < ROWS; r++) begin
            if (wwl_o[r]) begin
                for (int c = 0; c < COLS; c++) begin
                    if (slt_o[r] && slb_o[r] && !wbl_o[c]) cells[r][c] = 1'b0;
                    else if (!slt_o[r] && !slb_o[r] && wbl_o[c]) cells[r][c] = 1'b1;
                end
            end
        end
    end

    // monitor / scoreboard
    int  k = 0;
    bit  active = 0;
    bit  e2, e3, e4, e5;
    logic [63:0] a2, a3, a4, a5;
    always @(negedge clk) begin
        if (rst_n && busy_o) begin
            txn_t t;
            logic [ROWS-1:0] sel;
            int L;
            if (!active) begin
                active = 1; k = 0;
                e2 = 0; e3 = 0; e4 = 0; e5 = 0;
            end
            if (exp_q.size() == 0) begin
                check(0, "R7 busy without queued request", 1, 0);
                active = 0;
            end else begin
                t = exp_q[0];
                L = (t.len == 0) ? 1 : t.len;
                sel = '0; sel[t.row] = 1'b1;
                if (k < L) begin
                    if (!(wwl_o == sel && slt_o == sel && slb_o == sel && wbl_o == t.data && !done_o)) begin
                        e2 = 1; a2 = {wwl_o, slt_o, wbl_o};
                    end
                end else if (k < L + GAP) begin
                    if (!(wwl_o == '0 && slt_o == '0 && slb_o == '0 && wbl_o == '0 && !done_o)) begin
                        e3 = 1; a3 = {wwl_o, slt_o, wbl_o};
                    end
                end else if (k < 2*L + GAP) begin
                    if (!(wwl_o == sel && slt_o == '0 && slb_o == '0 && wbl_o == t.data && !done_o)) begin
                        e4 = 1; a4 = {wwl_o, slt_o, wbl_o};
                    end
                end
                if ((wwl_o & ~sel) != '0 || (slt_o & ~sel) != '0 || (slb_o & ~sel) != '0) begin
                    e5 = 1; a5 = {wwl_o, slt_o};
                end
                if (done_o) begin
                    void'(exp_q.pop_front());
                    check(!e2, "R2 phase one enables", a2, {sel, sel, t.data});
                    check(!e3, "R3 gap enables", a3, 0);
                    check(!e4, "R4 phase two enables", a4, {sel, {ROWS{1'b0}}, t.data});
                    check(!e5, "R5 unselected rows", a5, 0);
                    check(k == 2*L + GAP, "R6 R8 done offset", k, 2*L + GAP);
                    shadow[t.row] = t.data;
                    check(cells[t.row] == t.data, "R9 row contents", cells[t.row], t.data);
                    for (int r = 0; r < ROWS; r++) begin
                        if (r != t.row)
                            check(cells[r] == shadow[r], "R9 other row unchanged", cells[r], shadow[r]);
                    end
                    active = 0;
                    txn_done++;
                end
                k++;
            end
        end else if (rst_n && active) begin
            check(0, "R6 busy fell without done", 0, 1);
            active = 0;
        end
    end

    task automatic write_row(input logic [ROW_W-1:0] r, input logic [COLS-1:0] d, input int len);
        txn_t t;
        while (busy_o) @(negedge clk);
        t.row = r; t.data = d; t.len = len;
        exp_q.push_back(t);
        row_i = r; data_i = d; len_i = CNT_W'(len); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy_o || exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        for (int r = 0; r < ROWS; r++) begin
            cells[r]  = COLS'(16'hA5C3 ^ (r * 16'h1111));
            shadow[r] = cells[r];
        end
        repeat (3) @(negedge clk);
        // R1 reset state
        check(wwl_o == '0 && slt_o == '0 && slb_o == '0 && wbl_o == '0,
              "R1 drivers low in reset", {wwl_o, slt_o, wbl_o}, 0);
        check(!busy_o && !done_o, "R1 status low in reset", {busy_o, done_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(wwl_o == '0 && !busy_o && !done_o, "R1 idle after reset", {wwl_o, busy_o}, 0);

        // R2 R4 R9 mixed data, several lengths
        write_row(3'd2, 16'h0F35, 3);
        wait_idle();
        write_row(3'd0, 16'hFFFF, 2);
        wait_idle();
        write_row(3'd7, 16'h0000, 4);
        wait_idle();
        // R8 zero length behaves as one
        write_row(3'd5, 16'h8001, 0);
        wait_idle();
        // back-to-back requests
        write_row(3'd3, 16'h5A5A, 1);
        write_row(3'd2, 16'hC3C3, 2);
        wait_idle();

        // R7 start while busy is ignored
        write_row(3'd4, 16'h1234, 5);
        repeat (2) @(negedge clk);
        row_i = 3'd6; data_i = 16'hFFFF; len_i = 8'd1; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_idle();
        check(cells[6] == shadow[6], "R7 ignored request left row intact", cells[6], shadow[6]);
        check(!busy_o && !done_o, "R7 no extra operation", {busy_o, done_o}, 0);
        check(txn_done == 7, "R6 completed operations", txn_done, 7);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule